// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Coherent Byte Reload

The block is a 16-bit up/down counter that drives a set of center-aligned PWM outputs. It is programmed through an 8-bit register port. The counter climbs from zero to a modulo value and falls back to zero, so each PWM period lasts twice the modulo in counter clocks. Each channel compares its value with the counter. The result on the rising slope and the result on the falling slope act in opposite directions, so the high pulse sits around the counter's zero point.

Modulo and channel values are 16 bits wide but arrive one byte at a time. Each byte lands in a shadow buffer that keeps a separate "written" flag for the high byte and for the low byte. A buffer moves into its active register only after both bytes have arrived, in either order:
- When the counter is stopped, the move happens on the write that completes the pair.
- When the counter is running, the move waits for the counter to step up into the modulo value.

Writing a control register throws away a half-written value. A sticky overflow flag, with an interrupt enable, marks each visit of the counter to the modulo value.

The write port is a valid/ready channel. `wr_ready` is held high, so the port never applies back-pressure. A beat is taken on every clock edge where `wr_valid` is high. The read port is combinational and returns committed state only.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the counter is 0 and counts up. While running, it steps by one toward the modulo M, turns down at M, turns up at 0, and repeats, so the period is 2*M clocks. A modulo of 0 means a turnaround at 0xFFFF. With the clock select (control register address 0, bits [1:0]) at 00 the counter holds its value; any other code runs it once per clock.
- R2: With polarity 0 and a channel value V where 0 < V < M, the output goes low on the edge after the counter equals V while counting up, and high on the edge after it equals V while counting down. The output is high for exactly 2*V clocks of every period.
- R3: Polarity is bit 0 of a channel's control register (address 5+3*c). A 1 inverts the channel output, giving a high time of 2*M - 2*V.
- R4: A channel value of 0 keeps the output at its inactive level. A value at or above M keeps it at its active level.
- R5: Modulo bytes (high at address 3, low at address 4) and channel value bytes (high at 6+3*c, low at 7+3*c) are written into buffers. Reading those addresses returns the active value, which does not change while only one byte of a pair has been written.
- R6: With the counter stopped, a buffer becomes active on the clock edge of the write that completes its byte pair, whichever byte comes first.
- R7: With the counter running, a complete buffer becomes active on the clock edge where the counter steps up from M-1 to M. The modulo buffer and the channel buffers follow the same rule.
- R8: A write to the timer control register (address 0) discards a half-written modulo. A write to a channel control register discards that channel's half-written value.
- R9: The overflow flag (control bit 7) is set on the edge that leaves the count M while counting up. Writing 1 to bit 7 clears it, but a set on the same edge wins. When the enable (control bit 6) is 1, `irq_o` follows the flag.
- R10: `wr_ready` is always 1. Each clock edge with `wr_valid` high performs exactly one register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat accepted (held at 1) |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | 8 | Read data byte (combinational) |
| pwm_o | output | NUM_CH | PWM channel outputs |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The overflow flag can be set by the counter and cleared by software on the same edge. The bench provokes this by polling the counter through the read port and, at the sample where it reads M, issuing a write-1-to-clear that lands on the edge leaving M. The flag must read 1 afterwards. A byte commit meeting the counter's step into M is judged the same way: the bench samples the active value and the count together, and the first sample showing the new value must show count M, with M-1 at the sample before.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  localparam int CNT_W     = 16;
  localparam int A_CTRL    = 0;
  localparam int A_CNT_HI  = 1;
  localparam int A_CNT_LO  = 2;
  localparam int A_MOD_HI  = 3;
  localparam int A_MOD_LO  = 4;
  localparam int A_CH0     = 5;
  localparam int CH_STRIDE = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    CLK_OFF  = 2'b00,
    CLK_RUN1 = 2'b01,
    CLK_RUN2 = 2'b10,
    CLK_RUN3 = 2'b11
  } clk_sel_e;

  function automatic int ch_base(input int c);
    return A_CH0 + CH_STRIDE * c;
  endfunction

  function automatic int addr_width(input int n);
    return $clog2(A_CH0 + CH_STRIDE * n);
  endfunction
endpackage

// File: rtl/cpwm_updown_cnt.sv
`timescale 1ns/1ps
module cpwm_updown_cnt
  import cpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t top,
  output cnt_t cnt,
  output logic cnt_up,
  output cnt_t cnt_nxt,
  output logic up_nxt,
  output logic commit_pt,
  output logic at_peak
);
  // next-state of the triangle counter
  always_comb begin
    cnt_nxt = cnt;
    up_nxt  = cnt_up;
    if (run) begin
      if (cnt_up) begin
        if (cnt >= top) begin
          up_nxt  = 1'b0;
          cnt_nxt = cnt - cnt_t'(1);
        end else begin
          cnt_nxt = cnt + cnt_t'(1);
        end
      end else begin
        if (cnt == '0) begin
          up_nxt  = 1'b1;
          cnt_nxt = cnt_t'(1);
        end else begin
          cnt_nxt = cnt - cnt_t'(1);
        end
      end
    end
  end

  // safe reload point: stepping upward into the modulo value
  assign commit_pt = run && up_nxt && (cnt_nxt == top) && (cnt != top);
  // counter sits on (or above) the modulo while rising
  assign at_peak   = run && cnt_up && (cnt >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else begin
      cnt    <= cnt_nxt;
      cnt_up <= up_nxt;
    end
  end
endmodule

// File: rtl/cpwm_coh_buf.sv
`timescale 1ns/1ps
module cpwm_coh_buf
  import cpwm_pkg::*;
#(
  parameter cnt_t RST_VAL = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       commit_pt,
  input  logic       cancel,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [7:0] wdata,
  output cnt_t       active_o
);
  logic       hi_f, lo_f;
  logic [7:0] hi_b, lo_b;
  logic [7:0] hi_n, lo_n;
  logic       commit_stop, commit_run;

  always_comb begin
    hi_n = wr_hi ? wdata : hi_b;
    lo_n = wr_lo ? wdata : lo_b;
  end

  // stopped: pair completes this edge; running: complete pair meets reload point
  assign commit_stop = !run && (hi_f || wr_hi) && (lo_f || wr_lo);
  assign commit_run  = run && hi_f && lo_f && commit_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_f     <= 1'b0;
      lo_f     <= 1'b0;
      hi_b     <= '0;
      lo_b     <= '0;
      active_o <= RST_VAL;
    end else begin
      hi_b <= hi_n;
      lo_b <= lo_n;
      if (cancel || commit_stop) begin
        hi_f <= 1'b0;
        lo_f <= 1'b0;
      end else begin
        hi_f <= wr_hi || (hi_f && !commit_run);
        lo_f <= wr_lo || (lo_f && !commit_run);
      end
      if (commit_stop) begin
        active_o <= {hi_n, lo_n};
      end else if (commit_run) begin
        active_o <= {hi_b, lo_b};
      end
    end
  end
endmodule

// File: rtl/cpwm_channel.sv
`timescale 1ns/1ps
module cpwm_channel
  import cpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t cnt,
  input  logic cnt_up,
  input  cnt_t top,
  input  cnt_t val,
  input  logic pol,
  output logic pwm
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (val == '0) begin
      lvl_q <= 1'b0;
    end else if (val >= top) begin
      lvl_q <= 1'b1;
    end else if (run && (cnt == val)) begin
      // rising slope ends the pulse, falling slope starts it
      lvl_q <= !cnt_up;
    end
  end

  assign pwm = lvl_q ^ pol;
endmodule

// File: rtl/cpwm_timer.sv
`timescale 1ns/1ps
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = addr_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_CNT_HI = ADDR_W'(A_CNT_HI);
  localparam logic [ADDR_W-1:0] AD_CNT_LO = ADDR_W'(A_CNT_LO);
  localparam logic [ADDR_W-1:0] AD_MOD_HI = ADDR_W'(A_MOD_HI);
  localparam logic [ADDR_W-1:0] AD_MOD_LO = ADDR_W'(A_MOD_LO);

  clk_sel_e   clk_sel;
  logic       ovf_ie;
  logic       ovf_flag;
  logic       run;
  logic       wr_fire;
  logic       ctrl_we;
  cnt_t       cnt, cnt_nxt, mod_act, top;
  logic       cnt_up, up_nxt, commit_pt, at_peak;
  logic [7:0] csc_q [NUM_CH];
  cnt_t       ch_val [NUM_CH];
  logic [NUM_CH-1:0] ch_pol;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign ctrl_we  = wr_fire && (wr_addr == AD_CTRL);
  assign run      = (clk_sel != CLK_OFF);
  assign top      = (mod_act == '0) ? '1 : mod_act;

  // timer control / overflow flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel  <= CLK_OFF;
      ovf_ie   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (ctrl_we) begin
        clk_sel <= clk_sel_e'(wr_data[1:0]);
        ovf_ie  <= wr_data[6];
      end
      if (at_peak) begin
        ovf_flag <= 1'b1;
      end else if (ctrl_we && wr_data[7]) begin
        ovf_flag <= 1'b0;
      end
    end
  end

  assign irq_o = ovf_flag && ovf_ie;

  cpwm_updown_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .top       (top),
    .cnt       (cnt),
    .cnt_up    (cnt_up),
    .cnt_nxt   (cnt_nxt),
    .up_nxt    (up_nxt),
    .commit_pt (commit_pt),
    .at_peak   (at_peak)
  );

  cpwm_coh_buf #(.RST_VAL('0)) u_mod_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .commit_pt (commit_pt),
    .cancel    (ctrl_we),
    .wr_hi     (wr_fire && (wr_addr == AD_MOD_HI)),
    .wr_lo     (wr_fire && (wr_addr == AD_MOD_LO)),
    .wdata     (wr_data),
    .active_o  (mod_act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] AD_CSC = ADDR_W'(ch_base(c));
    localparam logic [ADDR_W-1:0] AD_VHI = ADDR_W'(ch_base(c) + 1);
    localparam logic [ADDR_W-1:0] AD_VLO = ADDR_W'(ch_base(c) + 2);
    logic csc_we;

    assign csc_we = wr_fire && (wr_addr == AD_CSC);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        csc_q[c] <= '0;
      end else if (csc_we) begin
        csc_q[c] <= wr_data;
      end
    end

    assign ch_pol[c] = csc_q[c][0];

    cpwm_coh_buf #(.RST_VAL('0)) u_val_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .commit_pt (commit_pt),
      .cancel    (csc_we),
      .wr_hi     (wr_fire && (wr_addr == AD_VHI)),
      .wr_lo     (wr_fire && (wr_addr == AD_VLO)),
      .wdata     (wr_data),
      .active_o  (ch_val[c])
    );

    cpwm_channel u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .cnt    (cnt),
      .cnt_up (cnt_up),
      .top    (top),
      .val    (ch_val[c]),
      .pol    (ch_pol[c]),
      .pwm    (pwm_o[c])
    );
  end

  // committed-state read mux
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      AD_CTRL:   rd_data = {ovf_flag, ovf_ie, 4'b0000, clk_sel};
      AD_CNT_HI: rd_data = cnt[15:8];
      AD_CNT_LO: rd_data = cnt[7:0];
      AD_MOD_HI: rd_data = mod_act[15:8];
      AD_MOD_LO: rd_data = mod_act[7:0];
      default:   rd_data = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(ch_base(c)))     rd_data = csc_q[c];
      if (rd_addr == ADDR_W'(ch_base(c) + 1)) rd_data = ch_val[c][15:8];
      if (rd_addr == ADDR_W'(ch_base(c) + 2)) rd_data = ch_val[c][7:0];
    end
  end
endmodule

// File: rtl/cpwm_timer_chk.sv
`timescale 1ns/1ps
module cpwm_timer_chk
  import cpwm_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic run,
  input cnt_t cnt,
  input logic cnt_up,
  input cnt_t top,
  input cnt_t cnt_nxt,
  input logic up_nxt,
  input cnt_t mod_act,
  input cnt_t val0,
  input logic pol0,
  input logic pwm0,
  input logic ovf_flag,
  input logic wr_ready
);
  // R1: falling slope steps down by one
  p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_up && (cnt != '0) |=> cnt == $past(cnt) - cnt_t'(1));

  // R1: rising slope below the top steps up by one
  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt_up && (cnt < top) |=> cnt == $past(cnt) + cnt_t'(1));

  // R1: stopped counter holds
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R4: zero value keeps the output inactive
  p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (val0 == '0) && !pol0 |=> (pol0 || !pwm0));

  // R7: a running channel value only moves at the reload point
  p_val_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && !(up_nxt && (cnt_nxt == top) && (cnt != top)) |=> $stable(val0));

  // R7: a running modulo only moves at the reload point
  p_mod_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && !(up_nxt && (cnt_nxt == top) && (cnt != top)) |=> $stable(mod_act));

  // R9: the flag rises only after the counter sat at the top while rising
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(run && cnt_up && (cnt >= top)));

  // R10: the write port never stalls
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind cpwm_timer cpwm_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .cnt      (cnt),
  .cnt_up   (cnt_up),
  .top      (top),
  .cnt_nxt  (cnt_nxt),
  .up_nxt   (up_nxt),
  .mod_act  (mod_act),
  .val0     (ch_val[0]),
  .pol0     (ch_pol[0]),
  .pwm0     (pwm_o[0]),
  .ovf_flag (ovf_flag),
  .wr_ready (wr_ready)
);

// File: tb/cpwm_timer_tb.sv
`timescale 1ns/1ps
module cpwm_timer_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [NCH-1:0] pwm_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpwm_timer #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands on the following posedge
  task automatic wr(input int a, input int d);
    wr_valid = 1'b1;
    wr_addr  = AW'(a);
    wr_data  = 8'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd8(input int a, output int v);
    rd_addr = AW'(a);
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic rd16(input int a_hi, output int v);
    int h, l;
    rd8(a_hi, h);
    rd8(a_hi + 1, l);
    v = h * 256 + l;
  endtask

  function automatic int vhi(input int c); return 6 + 3 * c; endfunction

  task automatic setup(input int m, input int v0, input int v1, input int p1);
    wr(0, 0);
    wr(3, m >> 8); wr(4, m & 255);
    wr(5, 0); wr(8, p1);
    wr(vhi(0), v0 >> 8); wr(vhi(0) + 1, v0 & 255);
    wr(vhi(1), v1 >> 8); wr(vhi(1) + 1, v1 & 255);
    wr(0, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, c, prev, hi0, hi1, t0, t1, seen;
    repeat (3) @(negedge clk);
    // reset state (R1, R9)
    rd16(1, v);  check(v == 0, "R1 reset count", v, 0);
    rd16(3, v);  check(v == 0, "R5 reset modulo", v, 0);
    rd8(0, v);   check(v == 0, "R9 reset ctrl", v, 0);
    check(pwm_o == '0, "R4 reset outputs", int'(pwm_o), 0);
    check(irq_o == 1'b0, "R9 reset irq", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b1, "R10 ready", int'(wr_ready), 1);

    // sweep of duty over small modulos (R2, R3, R4, R6)
    for (int m = 2; m <= 5; m++) begin
      for (int d = 0; d <= m + 1; d++) begin
        int e0, e1;
        setup(m, d, d, 1);
        repeat (4 * m + 16) @(negedge clk);
        hi0 = 0; hi1 = 0;
        for (int k = 0; k < 2 * m; k++) begin
          hi0 += int'(pwm_o[0]);
          hi1 += int'(pwm_o[1]);
          @(negedge clk);
        end
        e0 = (d >= m) ? 2 * m : 2 * d;
        e1 = 2 * m - e0;
        check(hi0 == e0, (d == 0 || d >= m) ? "R4 ch0 level" : "R2 ch0 width", hi0, e0);
        check(hi1 == e1, "R3 ch1 inverted width", hi1, e1);
      end
    end

    // period and overflow (R1, R9)
    setup(5, 2, 3, 0);
    wr(0, 8'hC1);
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin rd8(0, v); seen = (v >> 7) & 1; if (!seen) @(negedge clk); end
    t0 = cyc;
    wr(0, 8'hC1);
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin rd8(0, v); seen = (v >> 7) & 1; if (!seen) @(negedge clk); end
    t1 = cyc;
    check(t1 - t0 == 10, "R1 period 2*M", t1 - t0, 10);
    check(irq_o == 1'b1, "R9 irq enabled", int'(irq_o), 1);
    wr(0, 8'h01);
    check(irq_o == 1'b0, "R9 irq masked", int'(irq_o), 0);
    rd8(0, v); check(((v >> 7) & 1) == 1, "R9 flag sticky", (v >> 7) & 1, 1);
    wr(0, 8'h81);
    rd8(0, v); check(((v >> 7) & 1) == 0, "R9 write-1 clear", (v >> 7) & 1, 0);
    // set and clear on the same edge: set wins
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin rd16(1, c); seen = (c == 5); if (!seen) @(negedge clk); end
    wr(0, 8'h81);
    rd8(0, v); check(((v >> 7) & 1) == 1, "R9 set beats clear", (v >> 7) & 1, 1);

    // running commit: half write holds, full write lands at M-1 -> M (R5, R7)
    wr(vhi(0), 0);
    repeat (25) @(negedge clk);
    rd16(vhi(0), v); check(v == 2, "R5 half write held", v, 2);
    wr(vhi(0) + 1, 4);
    prev = -1; seen = 0;
    for (int k = 0; k < 30 && !seen; k++) begin
      rd16(1, c); rd16(vhi(0), v);
      if (v == 4) begin
        seen = 1;
        check(c == 5 && prev == 4, "R7 channel commit point", c * 100 + prev, 504);
      end
      prev = c;
      @(negedge clk);
    end
    check(seen == 1, "R7 channel committed", seen, 1);

    // modulo commit running (R7)
    wr(4, 4); wr(3, 0);
    prev = -1; seen = 0;
    for (int k = 0; k < 30 && !seen; k++) begin
      rd16(1, c); rd16(3, v);
      if (v == 4) begin
        seen = 1;
        check(c == 5 && prev == 4, "R7 modulo commit point", c * 100 + prev, 504);
      end
      prev = c;
      @(negedge clk);
    end
    check(seen == 1, "R7 modulo committed", seen, 1);

    // cancellation (R8)
    wr(vhi(0), 0); wr(5, 0); wr(vhi(0) + 1, 3);
    repeat (25) @(negedge clk);
    rd16(vhi(0), v); check(v == 4, "R8 channel cancel", v, 4);
    wr(vhi(0), 0);
    repeat (25) @(negedge clk);
    rd16(vhi(0), v); check(v == 3, "R8 low-then-high completes", v, 3);
    wr(3, 0); wr(0, 8'h01); wr(4, 3);
    repeat (25) @(negedge clk);
    rd16(3, v); check(v == 4, "R8 modulo cancel", v, 4);

    // stopped commit on completing byte (R6)
    wr(0, 0);
    wr(vhi(1) + 1, 1);
    rd16(vhi(1), v); check(v == 3, "R6 one byte pending", v, 3);
    wr(vhi(1), 0);
    rd16(vhi(1), v); check(v == 1, "R6 immediate commit", v, 1);
    rd16(1, c);
    repeat (5) @(negedge clk);
    rd16(1, v); check(v == c, "R1 stopped holds", v, c);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule